// File: doc/BRIEF.md
# I2C-Controlled 8-Bit Port Expander

This block is an I2C target that gives a bus controller access to an 8-bit bidirectional pin port. The bus lines are cleaned by a synchronizer and a stability filter running on the fast system clock. The block then recognises START and STOP, answers to a 7-bit address whose low three bits come from strap inputs, and acknowledges every byte it accepts.

Four internal registers sit behind the bus: the pin-level register, the output latch, a polarity mask and a direction mask. The first byte after a write address is a command byte that picks one of them. Every later byte of that transfer is written to the picked register. A read transfer returns the picked register on each byte for as long as the controller keeps acknowledging.

The pin side is plain and has no handshake. The block drives per-pin enables and data and reads back the raw pin levels. SDA is an open-drain output in the form of a single pull-low enable. The serial bus sets all flow control, so the block has no valid/ready stream. The system clock must be at least 20 times the SCL rate.

Top module: `ioexp_top`

## Requirements
- R1: After reset, all pin enables are 0, all pin data outputs are 0, SDA is released, the direction register reads 0xFF, and the output latch and polarity mask read 0x00.
- R2: A pulse on SCL or SDA shorter than FILT_TAPS system clocks has no effect on the bus state. A 2-clock low glitch on SDA while SCL is high does not end or corrupt a transfer.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. STOP always releases SDA and returns the block to idle, and a byte cut short by STOP is not written. A START inside a transfer restarts address reception.
- R4: The address byte is sent MSB first, with R/W as bit 0 (1 = read). The block pulls SDA low during the ninth clock only when bits 7:1 equal {ADDR_BASE[6:3], strap_i}. Any other address gets no acknowledge.
- R5: In a write, the byte after the address is the command and later bytes go to the register it selects. Codes are 0 pin levels, 1 output latch, 2 polarity, 3 direction. Every written byte is acknowledged.
- R6: Writes using command 0 or any code of 4 or more change no register and no pin output.
- R7: A direction bit of 1 makes the pin an input, with enable 0 and data 0. A direction bit of 0 gives enable 1 and data equal to the output latch bit.
- R8: Reading command 0 returns the pin levels XOR the polarity mask, for input and output pins alike.
- R9: Reading command 1 returns the output latch, not the pin levels, including bits whose pins are inputs.
- R10: A read returns the register of the last command on every byte while the controller acknowledges. Codes of 4 or more read as 0x00. After a NACK, SDA stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_i | input | STRAP_W | Low address bits |
| pin_i | input | 8 | Raw pin levels |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_do_o | output | 8 | Per-pin output data |

## Verification
The bench builds the block with ADDR_BASE = 7'h48, a strap of 3'b101, SYNC_STAGES = 2 and FILT_TAPS = 3. The device address is therefore 0x4D. A neighbour address that differs only in a strap bit shows that the strap takes part in matching. A three-tap filter puts a 2-clock SDA glitch just below the rejection limit, so that case is exercised directly. With 12 system clocks per SCL phase, read bits driven by the block are sampled well after the filter delay has elapsed.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_PINS = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_POL  = 2'd2,
    SEL_DIR  = 2'd3
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WBYTE,
    ST_WACK,
    ST_RBYTE,
    ST_RACK
  } bus_st_e;
endpackage

// File: rtl/ioexp_filter.sv
module ioexp_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int TAPS        = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      win_q  <= {win_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      if (&win_q)       line_o <= 1'b1;
      else if (~|win_q) line_o <= 1'b0;
    end
  end

  // R2: the cleaned level needs a full stable window, so it never toggles twice in a row
  a_r2_no_back_to_back_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_o) |=> $stable(line_o));
endmodule

// File: rtl/ioexp_bus.sv
module ioexp_bus
  import ioexp_pkg::*;
#(
  parameter int         STRAP_W   = 3,
  parameter logic [6:0] ADDR_BASE = 7'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_stb_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] cmd_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  bus_st_e           st_q;
  logic              scl_d, sda_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q;
  logic              rw_q, cmd_ph_q, nack_q;
  logic              scl_rise, scl_fall, start_det, stop_det, byte_done, addr_hit;

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_det = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;
  assign byte_done = (cnt_q == CNT_W'(BYTE_W));
  assign addr_hit  = (sh_q[BYTE_W-1:STRAP_W+1] == ADDR_BASE[6:STRAP_W]) &&
                     (sh_q[STRAP_W:1] == strap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      cnt_q     <= '0;
      sh_q      <= '0;
      tx_q      <= '0;
      rw_q      <= 1'b0;
      cmd_ph_q  <= 1'b0;
      nack_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_data_o <= '0;
      cmd_o     <= '0;
    end else begin
      scl_d    <= scl_f;
      sda_d    <= sda_f;
      wr_stb_o <= 1'b0;
      if (stop_det) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_det) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR, ST_WBYTE: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_f};
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall && byte_done) begin
              if (st_q == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= sh_q[0];
                  st_q     <= ST_AACK;
                end else begin
                  st_q <= ST_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                st_q     <= ST_WACK;
                if (cmd_ph_q) begin
                  cmd_o <= sh_q;
                end else begin
                  wr_stb_o  <= 1'b1;
                  wr_data_o <= sh_q;
                end
              end
            end
          end
          ST_AACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q     <= {rd_data_i[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                st_q     <= ST_RBYTE;
              end else begin
                sda_oe_o <= 1'b0;
                cmd_ph_q <= 1'b1;
                st_q     <= ST_WBYTE;
              end
            end
          end
          ST_WACK: begin
            if (scl_fall) begin
              sda_oe_o <= 1'b0;
              cnt_q    <= '0;
              cmd_ph_q <= 1'b0;
              st_q     <= ST_WBYTE;
            end
          end
          ST_RBYTE: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + CNT_W'(1);
            end else if (scl_fall) begin
              if (byte_done) begin
                sda_oe_o <= 1'b0;
                st_q     <= ST_RACK;
              end else begin
                sda_oe_o <= ~tx_q[BYTE_W-1];
                tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack_q <= sda_f;
            end else if (scl_fall) begin
              if (nack_q) begin
                st_q <= ST_IDLE;
              end else begin
                cnt_q    <= '0;
                tx_q     <= {rd_data_i[BYTE_W-2:0], 1'b0};
                sda_oe_o <= ~rd_data_i[BYTE_W-1];
                st_q     <= ST_RBYTE;
              end
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  a_r3_stop_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st_q == ST_IDLE) && !sda_oe_o);
  a_r4_idle_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_oe_o);
  a_r5_write_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (st_q == ST_WACK) && sda_oe_o);
  a_r10_drive_only_when_owner: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (st_q == ST_AACK) || (st_q == ST_WACK) || (st_q == ST_RBYTE));
endmodule

// File: rtl/ioexp_regs.sv
module ioexp_regs
  import ioexp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pin_i,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [BYTE_W-1:0] cmd_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [BYTE_W-1:0] pin_oe_o,
  output logic [BYTE_W-1:0] pin_do_o
);
  logic [BYTE_W-1:0] pin_s1_q, pin_s2_q, lat_q, pol_q, dir_q;
  logic              cmd_ok;
  reg_sel_e          sel;

  assign cmd_ok = (cmd_i[BYTE_W-1:SEL_W] == '0);
  assign sel    = reg_sel_e'(cmd_i[SEL_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1_q <= '0;
      pin_s2_q <= '0;
      lat_q    <= '0;
      pol_q    <= '0;
      dir_q    <= '1;
    end else begin
      pin_s1_q <= pin_i;
      pin_s2_q <= pin_s1_q;
      if (wr_stb_i && cmd_ok) begin
        case (sel)
          SEL_LAT: lat_q <= wr_data_i;
          SEL_POL: pol_q <= wr_data_i;
          SEL_DIR: dir_q <= wr_data_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (cmd_ok) begin
      case (sel)
        SEL_PINS: rd_data_o = pin_s2_q ^ pol_q;
        SEL_LAT:  rd_data_o = lat_q;
        SEL_POL:  rd_data_o = pol_q;
        SEL_DIR:  rd_data_o = dir_q;
        default:  rd_data_o = '0;
      endcase
    end
  end

  for (genvar b = 0; b < BYTE_W; b++) begin : g_pin
    assign pin_oe_o[b] = ~dir_q[b];
    assign pin_do_o[b] = dir_q[b] ? 1'b0 : lat_q[b];
  end

  a_r6_ignored_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && (!cmd_ok || sel == SEL_PINS)) |=> $stable(lat_q) && $stable(pol_q) && $stable(dir_q));
  a_r7_dir_moves_on_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb_i && cmd_ok && sel == SEL_DIR) |=> $stable(pin_oe_o));
  a_r7_inputs_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pin_oe_o) & pin_do_o) == '0);
endmodule

// File: rtl/ioexp_top.sv
module ioexp_top
  import ioexp_pkg::*;
#(
  parameter int         STRAP_W     = 3,
  parameter logic [6:0] ADDR_BASE   = 7'h18,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_TAPS   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  pin_i,
  output logic [BYTE_W-1:0]  pin_oe_o,
  output logic [BYTE_W-1:0]  pin_do_o
);
  localparam int LINES = 2;

  logic [LINES-1:0]  raw, clean;
  logic              wr_stb;
  logic [BYTE_W-1:0] wr_data, cmd, rd_data;

  assign raw = {sda_i, scl_i};

  for (genvar l = 0; l < LINES; l++) begin : g_filt
    ioexp_filter #(.SYNC_STAGES(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(raw[l]), .line_o(clean[l])
    );
  end

  ioexp_bus #(.STRAP_W(STRAP_W), .ADDR_BASE(ADDR_BASE)) u_bus (
    .clk(clk), .rst_n(rst_n), .scl_f(clean[0]), .sda_f(clean[1]),
    .strap_i(strap_i), .rd_data_i(rd_data), .sda_oe_o(sda_oe_o),
    .wr_stb_o(wr_stb), .wr_data_o(wr_data), .cmd_o(cmd)
  );

  ioexp_regs u_regs (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_stb_i(wr_stb),
    .wr_data_i(wr_data), .cmd_i(cmd), .rd_data_o(rd_data),
    .pin_oe_o(pin_oe_o), .pin_do_o(pin_do_o)
  );
endmodule

// File: tb/ioexp_top_bench.sv
module ioexp_top_bench;
  localparam int         T    = 12;
  localparam logic [6:0] BASE = 7'h48;
  localparam logic [2:0] STRP = 3'b101;
  localparam logic [6:0] DEV  = {BASE[6:3], STRP};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_oe, sda_bus;
  logic [7:0] pin_i = 8'h00;
  logic [7:0] pin_oe, pin_do;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] m_lat = 8'h00, m_pol = 8'h00, m_dir = 8'hFF;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  ioexp_top #(.STRAP_W(3), .ADDR_BASE(BASE), .SYNC_STAGES(2), .FILT_TAPS(3)) u_ioexp_top (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .strap_i(STRP), .pin_i(pin_i), .pin_oe_o(pin_oe), .pin_do_o(pin_do)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] c);
    if (c > 8'd3) return 8'h00;
    case (c[1:0])
      2'd0:    return pin_i ^ m_pol;
      2'd1:    return m_lat;
      2'd2:    return m_pol;
      default: return m_dir;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] c, input logic [7:0] d);
    if (c == 8'd1) m_lat = d;
    else if (c == 8'd2) m_pol = d;
    else if (c == 8'd3) m_dir = d;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wt(); repeat (T) @(negedge clk); endtask

  task automatic bstart(); sda_drv = 1; wt(); scl_drv = 1; wt(); sda_drv = 0; wt(); scl_drv = 0; wt(); endtask
  task automatic bstop(); sda_drv = 0; wt(); scl_drv = 1; wt(); sda_drv = 1; wt(); endtask

  task automatic bit_out(input logic b, input bit glitch);
    sda_drv = b; wt(); scl_drv = 1; wt();
    if (glitch) begin sda_drv = 0; repeat (2) @(negedge clk); sda_drv = b; end
    wt(); scl_drv = 0; wt();
  endtask

  task automatic bit_in(output logic b);
    sda_drv = 1; wt(); scl_drv = 1; wt(); b = sda_bus; wt(); scl_drv = 0; wt();
  endtask

  task automatic send_byte(input logic [7:0] v, input bit glitch, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(v[i], glitch && (i == 7));
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin bit_in(x); v[i] = x; end
    bit_out(~mack, 1'b0);
  endtask

  task automatic wr_reg(input logic [7:0] c, input logic [7:0] d, input bit glitch, input string req);
    logic a;
    bstart();
    send_byte({DEV, 1'b0}, 1'b0, a); chk({req, " addr ack R4"}, {7'd0, a}, 8'd1);
    send_byte(c, 1'b0, a);           chk({req, " cmd ack R5"}, {7'd0, a}, 8'd1);
    send_byte(d, glitch, a);         chk({req, " data ack R5"}, {7'd0, a}, 8'd1);
    bstop();
    model_write(c, d);
  endtask

  task automatic rd_reg(input logic [7:0] c, input int n, input string req);
    logic a;
    logic [7:0] v;
    bstart();
    send_byte({DEV, 1'b0}, 1'b0, a);
    send_byte(c, 1'b0, a);
    bstart();
    send_byte({DEV, 1'b1}, 1'b0, a); chk({req, " read addr ack R4"}, {7'd0, a}, 8'd1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, v);
      chk(req, v, exp_read(c));
    end
    chk({req, " released after NACK R10"}, {7'd0, sda_oe}, 8'd0);
    bstop();
  endtask

  task automatic chk_pins(input string req);
    chk({req, " oe"}, pin_oe, ~m_dir);
    chk({req, " do"}, pin_do, m_lat & ~m_dir);
  endtask

  initial begin
    logic a;
    logic [7:0] c, d;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_do", pin_do, 8'h00);
    chk("R1 sda_oe", {7'd0, sda_oe}, 8'd0);
    rd_reg(8'd3, 1, "R1 dir reset");
    rd_reg(8'd1, 1, "R1 latch reset");
    rd_reg(8'd2, 1, "R1 pol reset");

    // R4 neighbour address (strap bit differs) is not acknowledged
    bstart();
    send_byte({DEV ^ 7'h01, 1'b0}, 1'b0, a);
    chk("R4 wrong address nack", {7'd0, a}, 8'd0);
    bstop();

    // R7 direction and latch
    wr_reg(8'd3, 8'hF0, 1'b0, "R7 dir");
    wr_reg(8'd1, 8'hA5, 1'b0, "R7 latch");
    chk_pins("R7 mixed directions");

    // R9 latch read, not pins
    pin_i = 8'h00;
    rd_reg(8'd1, 1, "R9 latch readback");

    // R8 polarity
    wr_reg(8'd2, 8'h3C, 1'b0, "R8 pol");
    pin_i = 8'h96;
    rd_reg(8'd0, 1, "R8 pins xor pol");

    // R6 ignored writes
    wr_reg(8'd0, 8'hFF, 1'b0, "R6 pins write");
    chk_pins("R6 after pins write");
    rd_reg(8'd0, 1, "R6 pins unchanged");
    wr_reg(8'd7, 8'h00, 1'b0, "R6 bad code write");
    chk_pins("R6 after bad code");
    rd_reg(8'd1, 1, "R6 latch kept");
    rd_reg(8'd3, 1, "R6 dir kept");
    rd_reg(8'd7, 1, "R10 bad code reads zero");

    // R10 multi-byte read
    rd_reg(8'd3, 3, "R10 repeated byte");

    // R2 glitch on first data bit
    wr_reg(8'd1, 8'hC3, 1'b1, "R2 glitch write");
    chk_pins("R2 latch after glitch");

    // R3 STOP in the middle of a data byte
    bstart();
    send_byte({DEV, 1'b0}, 1'b0, a);
    send_byte(8'd1, 1'b0, a);
    for (int i = 0; i < 4; i++) bit_out(1'b0, 1'b0);
    bstop();
    chk("R3 released after STOP", {7'd0, sda_oe}, 8'd0);
    chk_pins("R3 cut byte not written");
    wr_reg(8'd3, 8'h00, 1'b0, "R3 next transfer");
    chk_pins("R3 all outputs");

    // R5 random mix
    for (int it = 0; it < 14; it++) begin
      c = 8'($urandom_range(0, 5));
      d = 8'($urandom);
      pin_i = 8'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        wr_reg(c, d, 1'b0, "R5 random write");
        chk_pins("R5 random pins");
      end else begin
        rd_reg(c, 2, "R10 random read");
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule